// File: doc/BRIEF.md
# TPM SPI Target with Wait-State Flow Control

This block is the device-facing end of a SPI link that gives a fast host access to the registers of a slow trusted-platform module. It runs on its own system clock, oversamples the SPI pins, and stalls the host in-band: it never stretches SCK. Every transaction begins with a four-byte command header. Once the header is in, the target keeps returning filler bytes with bit 0 low until the register side accepts the request. It then returns a single byte with bit 0 high, and the data bytes follow.

Toward the internal register logic the block offers a level request that is held until a one-cycle acknowledge arrives. Read data is taken one byte at a time with a take strobe. Write bytes are handed over one at a time with a valid strobe. After a complete transaction, when the host releases chip select, the target drives an active-low ready-for-next line low for a configurable number of system clocks. A short width is used by default, and a long width is used when the configuration input is high. Dropping chip select early abandons the transaction, and no pulse is sent.

Top module: `tpm_spi_flow_target`

## Requirements
- R1: Header byte 0 bit 7 set means read, clear means write. Byte 0 bits 5:0 carry length minus one, giving 1 to 64 bytes. Bytes 1 to 3 carry a 24-bit address, most significant byte first. After the fourth header byte, reg_req rises with reg_write, reg_addr and reg_len decoded from the header.
- R2: MISO stays 0 for all four header bytes.
- R3: Each byte after the header that is loaded before the acknowledge has been seen is 0x00 (bit 0 clear).
- R4: The first byte loaded after the acknowledge is 0x01. The data phase starts on the byte after it.
- R5: In a read, the data bytes on MISO are rd_byte values sent MSB first. rd_take pulses exactly once per data byte, reg_len times in total.
- R6: In a write, wr_valid pulses once per data byte, carrying the byte in wr_byte, for exactly reg_len bytes after the 0x01 byte. Bytes received during the header, during the wait phase or after the last data byte are never forwarded.
- R7: When chip select is released after all data bytes have been transferred, rdy_n goes low for exactly SHORT_CYCLES clocks while long_pulse_cfg is 0. rdy_n is high after reset.
- R8: When long_pulse_cfg is 1, the pulse lasts exactly LONG_CYCLES clocks.
- R9: Releasing chip select before the data phase completes abandons the transaction. No rdy_n pulse is sent, reg_req drops, and the next transaction is decoded from a fresh header.
- R10: reg_req stays high until reg_ack is sampled high with it, and is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| rdy_n | output | 1 | Active-low ready-for-next pulse toward the host |
| long_pulse_cfg | input | 1 | Selects the long ready-pulse width |
| reg_req | output | 1 | Register access requested, held until reg_ack |
| reg_write | output | 1 | Requested access is a write |
| reg_addr | output | 24 | Requested register address |
| reg_len | output | 7 | Requested byte count, 1 to 64 |
| reg_ack | input | 1 | Register side ready to move data |
| rd_byte | input | 8 | Next read byte from the register side |
| rd_take | output | 1 | rd_byte has been taken for transmission |
| wr_valid | output | 1 | wr_byte holds a received write byte |
| wr_byte | output | 8 | Write data byte |

## Verification
Each SPI pin passes through two synchronizer stages and one edge register. A byte chosen at an SCK falling edge therefore appears on MISO about three system clocks later. The bench acts as the host and samples MISO at its own next rising SCK edge, half an SCK period (eight clocks) after the fall. reg_req rises a few clocks after the last header rising edge, so the bench polls for it. The bench then waits ten clocks after the byte's final fall before acknowledging, so that the acknowledge lands between two loads and the count of wait bytes is fixed. The ready pulse starts about three clocks after chip select is released. The bench waits for its falling edge and counts low cycles at the falling clock edge, which gives the exact width.

// File: rtl/tpm_spi_flow_pkg.sv
package tpm_spi_flow_pkg;

  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 7;
  localparam int ADDR_W    = 24;
  localparam int HDR_W     = 8 * HDR_BYTES;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WAIT = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  function automatic logic hdr_is_read(input logic [HDR_W-1:0] h);
    return h[HDR_W-1];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_len(input logic [HDR_W-1:0] h);
    return {1'b0, h[HDR_W-3:HDR_W-8]} + LEN_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_addr(input logic [HDR_W-1:0] h);
    return h[ADDR_W-1:0];
  endfunction

  function automatic logic [7:0] wait_byte(input logic ready);
    return {7'b0, ready};
  endfunction

endpackage

// File: rtl/tpm_spi_sync.sv
module tpm_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_end,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_p, csn_p, mosi_p;
  logic sck_q, csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
      sck_q  <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sck_p  <= {sck_p[STAGES-2:0], sck};
      csn_p  <= {csn_p[STAGES-2:0], csn};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      sck_q  <= sck_p[STAGES-1];
      csn_q  <= csn_p[STAGES-1];
    end
  end

  assign cs_active = ~csn_p[STAGES-1];
  assign cs_end    = csn_p[STAGES-1] & ~csn_q;
  assign sck_rise  = cs_active & sck_p[STAGES-1] & ~sck_q;
  assign sck_fall  = cs_active & ~sck_p[STAGES-1] & sck_q;
  assign mosi_s    = mosi_p[STAGES-1];

endmodule

// File: rtl/tpm_spi_shift.sv
module tpm_spi_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       load_slot,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_acc;
  logic [7:0] tx_sr;

  assign load_slot = cs_active & sck_fall & (bit_cnt == 3'd0);
  assign miso      = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_acc    <= '0;
      rx_byte   <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
    end else if (!cs_active) begin
      bit_cnt   <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_acc  <= {rx_acc[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte   <= {rx_acc, mosi_s};
          byte_done <= 1'b1;
        end
      end
      if (sck_fall) begin
        tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
      end
    end
  end

  AST_BYTE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(cs_active)); // R9

endmodule

// File: rtl/tpm_spi_rdy_pulse.sv
module tpm_spi_rdy_pulse #(
  parameter int SHORT_CYCLES = 100,
  parameter int LONG_CYCLES  = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic rdy_n
);
  localparam int MAXC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= long_sel ? CW'(LONG_CYCLES) : CW'(SHORT_CYCLES);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign rdy_n = (cnt == '0);

  AST_PULSE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(start)); // R7

  AST_PULSE_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |=> !rdy_n); // R8

endmodule

// File: rtl/tpm_spi_flow_target.sv
module tpm_spi_flow_target
  import tpm_spi_flow_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SHORT_CYCLES = 100,
  parameter int LONG_CYCLES  = 2400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              rdy_n,
  input  logic              long_pulse_cfg,
  output logic              reg_req,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [LEN_W-1:0]  reg_len,
  input  logic              reg_ack,
  input  logic [7:0]        rd_byte,
  output logic              rd_take,
  output logic              wr_valid,
  output logic [7:0]        wr_byte
);
  logic sck_rise, sck_fall, cs_active, cs_end, mosi_s;
  logic load_slot, byte_done;
  logic [7:0] rx_byte, tx_byte;

  phase_t          ph;
  logic [1:0]      hdr_cnt;
  logic [HDR_W-1:0] hdr_sr;
  logic [LEN_W-1:0] data_cnt;
  logic            ack_seen, ready_sent;
  logic            is_read, pulse_start;

  tpm_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active),
    .cs_end(cs_end), .mosi_s(mosi_s)
  );

  tpm_spi_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_byte(tx_byte),
    .load_slot(load_slot), .byte_done(byte_done), .rx_byte(rx_byte),
    .miso(spi_miso)
  );

  tpm_spi_rdy_pulse #(.SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(pulse_start), .long_sel(long_pulse_cfg),
    .rdy_n(rdy_n)
  );

  assign is_read   = hdr_is_read(hdr_sr);
  assign reg_write = ~is_read;
  assign reg_addr  = hdr_addr(hdr_sr);
  assign reg_len   = hdr_len(hdr_sr);
  assign reg_req   = cs_active & (ph == PH_WAIT) & ~ack_seen;

  always_comb begin
    case (ph)
      PH_WAIT: tx_byte = wait_byte(ack_seen);
      PH_DATA: tx_byte = is_read ? rd_byte : 8'h00;
      default: tx_byte = 8'h00;
    endcase
  end

  assign rd_take     = load_slot & (ph == PH_DATA) & is_read;
  assign wr_valid    = byte_done & (ph == PH_DATA) & ~is_read;
  assign wr_byte     = rx_byte;
  assign pulse_start = cs_end & (ph == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_HDR;
      hdr_cnt    <= '0;
      hdr_sr     <= '0;
      data_cnt   <= '0;
      ack_seen   <= 1'b0;
      ready_sent <= 1'b0;
    end else if (!cs_active) begin
      ph         <= PH_HDR;
      hdr_cnt    <= '0;
      data_cnt   <= '0;
      ack_seen   <= 1'b0;
      ready_sent <= 1'b0;
    end else begin
      if (reg_req && reg_ack) ack_seen <= 1'b1;
      if (load_slot && ph == PH_WAIT) ready_sent <= ack_seen;
      if (byte_done) begin
        case (ph)
          PH_HDR: begin
            hdr_sr  <= {hdr_sr[HDR_W-9:0], rx_byte};
            hdr_cnt <= hdr_cnt + 2'd1;
            if (hdr_cnt == 2'(HDR_BYTES - 1)) ph <= PH_WAIT;
          end
          PH_WAIT: begin
            if (ready_sent) begin
              ph       <= PH_DATA;
              data_cnt <= '0;
            end
          end
          PH_DATA: begin
            data_cnt <= data_cnt + LEN_W'(1);
            if (data_cnt == reg_len - LEN_W'(1)) ph <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_MISO_QUIET_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && ph == PH_HDR) |-> !spi_miso); // R2

  AST_REQ_HELD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack) |=> !reg_req); // R10

  AST_DATA_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA) |-> (data_cnt < reg_len)); // R5

  AST_TAKE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> ack_seen); // R5

  AST_WR_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (ready_sent && ack_seen)); // R6

  AST_PULSE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> !cs_active); // R7

endmodule

// File: tb/tb_tpm_spi_flow_target.sv
module tb_tpm_spi_flow_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int SHORT_C    = 100;
  localparam int LONG_C     = 2400;

  logic clk = 0, rst_n = 0;
  logic sck = 0, csn = 1, mosi = 0;
  logic miso, rdy_n, long_cfg = 0;
  logic reg_req, reg_write, reg_ack = 0;
  logic [23:0] reg_addr;
  logic [6:0]  reg_len;
  logic [7:0]  rd_byte, wr_byte;
  logic rd_take, wr_valid;

  logic [7:0] rd_mem [64];
  int         rd_idx;
  logic       rd_rst = 1;
  int         take_cnt;

  logic [7:0] exp_miso[$];
  string      exp_tag[$];
  logic [7:0] exp_wr[$];
  logic [7:0] host_rx;
  logic       host_stb = 0;
  int         n_cmp = 0, n_bad = 0, stray_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpm_spi_flow_target #(.SHORT_CYCLES(SHORT_C), .LONG_CYCLES(LONG_C)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .rdy_n(rdy_n), .long_pulse_cfg(long_cfg),
    .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_len(reg_len), .reg_ack(reg_ack), .rd_byte(rd_byte), .rd_take(rd_take),
    .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  assign rd_byte = rd_mem[rd_idx[5:0]];
  always @(posedge clk) begin
    if (rd_rst) begin rd_idx <= 0; take_cnt <= 0; end
    else if (rd_take) begin rd_idx <= rd_idx + 1; take_cnt <= take_cnt + 1; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (host_stb) begin
        if (exp_miso.size() == 0) check(0, "R2 unexpected MISO byte", host_rx, 0);
        else begin
          automatic logic [7:0] e = exp_miso.pop_front();
          automatic string t = exp_tag.pop_front();
          check(host_rx == e, t, host_rx, e);
        end
      end
      if (wr_valid) begin
        if (exp_wr.size() == 0) begin
          stray_wr++;
          check(0, "R6 stray write strobe", wr_byte, 0);
        end else begin
          automatic logic [7:0] e = exp_wr.pop_front();
          check(wr_byte == e, "R6 write byte", wr_byte, e);
        end
      end
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_byte(input logic [7:0] tx, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      clocks(HALF);
      sck = 1;
      got[b] = miso;
      clocks(HALF);
      sck = 0;
    end
    exp_miso.push_back(exp);
    exp_tag.push_back(tag);
    host_rx = got;
    host_stb = 1;
    @(posedge clk); #1;
    host_stb = 0;
  endtask

  task automatic send_header(input bit rd, input logic [23:0] addr, input int len);
    logic [7:0] b0;
    b0 = {rd, 1'b0, 6'(len - 1)};
    spi_byte(b0,         8'h00, "R2 header byte 0");
    spi_byte(addr[23:16],8'h00, "R2 header byte 1");
    spi_byte(addr[15:8], 8'h00, "R2 header byte 2");
    spi_byte(addr[7:0],  8'h00, "R2 header byte 3");
  endtask

  task automatic expect_pulse(input int width, input string tag);
    int w, t;
    w = 0; t = 0;
    while (rdy_n && t < 40) begin @(negedge clk); t++; end
    while (!rdy_n && w < LONG_C + 50) begin @(negedge clk); w++; end
    check(w == width, tag, w, width);
  endtask

  task automatic expect_no_pulse(input int span, input string tag);
    int lows;
    lows = 0;
    repeat (span) begin @(negedge clk); if (!rdy_n) lows++; end
    check(lows == 0, tag, lows, 0);
  endtask

  task automatic run_txn(input bit rd, input logic [23:0] addr, input int len,
                         input int waits, input bit extra, input int pw);
    int t;
    rd_rst = 1; clocks(2); rd_rst = 0;
    csn = 0; clocks(4);
    send_header(rd, addr, len);
    t = 0;
    while (!reg_req && t < 50) begin clocks(1); t++; end
    check(reg_req == 1, "R1 reg_req after header", reg_req, 1);
    check(reg_write == !rd, "R1 direction", reg_write, !rd);
    check(reg_addr == addr, "R1 address", reg_addr, addr);
    check(reg_len == 7'(len), "R1 length", reg_len, len);
    for (int i = 0; i < waits - 1; i++) begin
      spi_byte(8'hA5, 8'h00, "R3 wait byte");
      check(reg_req == 1, "R10 reg_req held", reg_req, 1);
    end
    clocks(10);
    reg_ack = 1; clocks(1); reg_ack = 0;
    clocks(1);
    check(reg_req == 0, "R10 reg_req drops after ack", reg_req, 0);
    spi_byte(8'h5A, 8'h00, "R3 last wait byte");
    spi_byte(8'hC3, 8'h01, "R4 ready byte");
    for (int i = 0; i < len; i++) begin
      if (rd) spi_byte(8'hFF, rd_mem[i], "R5 read data");
      else begin
        exp_wr.push_back(rd_mem[i]);
        spi_byte(rd_mem[i], 8'h00, "R6 write data");
      end
    end
    if (extra) spi_byte(8'h3C, 8'h00, "R6 byte past length");
    clocks(HALF);
    csn = 1;
    if (rd) check(take_cnt == len, "R5 rd_take count", take_cnt, len);
    expect_pulse(pw, long_cfg ? "R8 long pulse width" : "R7 short pulse width");
    check(exp_wr.size() == 0, "R6 all write bytes forwarded", exp_wr.size(), 0);
    clocks(20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) rd_mem[i] = 8'(i * 37 + 11);
    clocks(5);
    rst_n = 1;
    clocks(5);
    check(rdy_n == 1, "R7 rdy_n high after reset", rdy_n, 1);
    check(reg_req == 0, "R10 no request after reset", reg_req, 0);
    check(miso == 0, "R2 MISO low after reset", miso, 0);

    // read of 4 bytes, three wait bytes
    rd_mem[0] = 8'hE0; rd_mem[1] = 8'h1A; rd_mem[2] = 8'h28; rd_mem[3] = 8'h00;
    run_txn(1, 24'hD40F00, 4, 3, 0, SHORT_C);
    // single-byte write, one wait byte, extra byte past length
    rd_mem[0] = 8'h96;
    run_txn(0, 24'h000001, 1, 1, 1, SHORT_C);
    // 64-byte read with two wait bytes
    for (int i = 0; i < 64; i++) rd_mem[i] = 8'(i * 37 + 11);
    run_txn(1, 24'hABCDEF, 64, 2, 0, SHORT_C);
    // long pulse with a 5-byte write
    long_cfg = 1;
    run_txn(0, 24'h123456, 5, 4, 0, LONG_C);
    long_cfg = 0;

    // abort inside header
    csn = 0; clocks(4);
    spi_byte(8'h83, 8'h00, "R2 aborted header byte");
    spi_byte(8'h77, 8'h00, "R2 aborted header byte");
    clocks(HALF); csn = 1;
    expect_no_pulse(300, "R9 no pulse after header abort");

    // abort during wait phase
    rd_rst = 1; clocks(2); rd_rst = 0;
    csn = 0; clocks(4);
    send_header(0, 24'h0F0F0F, 8);
    spi_byte(8'h11, 8'h00, "R3 wait byte before abort");
    clocks(HALF); csn = 1;
    clocks(6);
    check(reg_req == 0, "R9 request dropped on abort", reg_req, 0);
    expect_no_pulse(300, "R9 no pulse after wait abort");

    // recovery: fresh transaction decoded correctly
    run_txn(1, 24'h00FE00, 2, 1, 0, SHORT_C);

    check(stray_wr == 0, "R6 no stray write strobes", stray_wr, 0);
    check(exp_miso.size() == 0, "R2 all MISO bytes compared", exp_miso.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule